// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block turns parallel characters from a host into an asynchronous serial bit stream. The host writes one character at a time into a single-byte holding register. When the shift stage is free, the block moves that byte into an 8-bit shift register. It then sends a start bit, the data bits least-significant first, an optional parity bit and one or two stop bits.

All bit timing comes from an oversampling tick. A free-running counter produces one tick every `divisor` clock cycles. The divisor is 16 bits wide and is supplied as a high byte and a low byte. Every serial bit lasts sixteen ticks, and a divisor of zero stops the transmitter.

Two flags tell the host where a character is. One shows that the holding register can take another byte. The other shows that the whole transmitter has drained. A maskable transmit-empty interrupt follows the first flag.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txOut` is 1, `holdEmpty` is 1, `txEmpty` is 1 and `irq` is 0. The line stays at 1 whenever no frame is being sent.
- R2: A frame is one start bit at 0, followed by the data bits sent least-significant first. The number of data bits is `dataLen`+5, so 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: When `parityEn` is 1, a parity bit follows the data bits. `parityMode` selects it: 0 makes the count of ones odd, 1 makes it even, 2 forces a 1 and 3 forces a 0.
- R4: The frame ends with one stop bit at 1, or two stop bits when `twoStop` is 1.
- R5: A tick occurs once every {`divHi`,`divLo`} clock cycles, and each serial bit lasts exactly 16 ticks.
- R6: While the divisor is zero, no tick occurs. The line and all frame progress hold still, and a written byte stays pending.
- R7: `holdEmpty` clears in the cycle after a write. It sets again in the same cycle that the byte moves into the shift register, which is the cycle the start bit begins.
- R8: `txEmpty` is 1 only when the holding register is empty and the last stop bit has completed.
- R9: A byte written while a frame is in progress starts its start bit directly after the current last stop bit, with no idle time between the frames.
- R10: `irq` equals `holdEmpty` while `irqEnable` is 1 and is 0 while `irqEnable` is 0. A write therefore clears a pending interrupt.
- R11: A second write before the pending byte has been transferred replaces that byte. Only the last value written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divHi | input | 8 | Upper byte of the tick divisor |
| divLo | input | 8 | Lower byte of the tick divisor |
| dataLen | input | 2 | Data length code (number of bits = code + 5) |
| parityEn | input | 1 | Insert a parity bit |
| parityMode | input | 2 | 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| twoStop | input | 1 | Send two stop bits instead of one |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to load into the holding register |
| irqEnable | input | 1 | Transmit-empty interrupt enable |
| txOut | output | 1 | Serial output line |
| holdEmpty | output | 1 | Holding register can accept a byte |
| txEmpty | output | 1 | Holding register and shift stage both empty |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The assertions check the following relations on every cycle:
- an empty transmitter always shows an idle-high line and an empty holding register;
- a write always clears the empty flag and the interrupt on the next cycle;
- the interrupt never fires while it is masked;
- the empty flag only rises when a frame begins;
- a zero divisor freezes the line.

Only the bench scenarios can show the rest:
- the bit order and the frame contents for each data length, parity mode and stop length;
- the exact bit duration for several divisors, including one that uses the high byte;
- the back-to-back joining of two frames;
- the replacement of a pending byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } parMode_t;

  typedef enum logic [1:0] {
    LINE_IDLE  = 2'd0,
    LINE_START = 2'd1,
    LINE_DATA  = 2'd2,
    LINE_PAR   = 2'd3
  } lineSel_t;

  typedef struct packed {
    logic     load;     // move holding byte into shift register
    logic     shift;    // advance to next data bit
    lineSel_t lineSel;  // what the serial line shows
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             divZero;

  assign divZero = (divisor == '0);
  assign tick    = !divZero && (cnt >= divisor - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (divZero) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      holdFull,
  input  logic [1:0] dataLen,
  input  logic      parityEn,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam int SUB_W = $clog2(OVS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } state_t;

  state_t           state;
  logic [SUB_W-1:0] subCnt;
  logic [2:0]       bitCnt;
  logic             bitEnd;
  logic             lastStop;
  logic             lastData;

  assign bitEnd   = tick && (subCnt == SUB_W'(OVS - 1));
  assign lastStop = !twoStop || (bitCnt == 3'd1);
  assign lastData = (bitCnt == 3'(dataLen + 2'd0) + 3'd4);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe.load  = tick && holdFull &&
                   ((state == ST_IDLE) || ((state == ST_STOP) && bitEnd && lastStop));
    strobe.shift = (state == ST_DATA) && bitEnd;
    case (state)
      ST_START: strobe.lineSel = LINE_START;
      ST_DATA:  strobe.lineSel = LINE_DATA;
      ST_PAR:   strobe.lineSel = LINE_PAR;
      default:  strobe.lineSel = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      state  <= ST_START;
      subCnt <= '0;
      bitCnt <= '0;
    end else if (state != ST_IDLE && tick) begin
      subCnt <= subCnt + 1'b1;
      if (bitEnd) begin
        case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (lastData) begin
              state  <= parityEn ? ST_PAR : ST_STOP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_PAR: begin
            state  <= ST_STOP;
            bitCnt <= '0;
          end
          ST_STOP: begin
            if (lastStop) state  <= ST_IDLE;
            else          bitCnt <= bitCnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_data.sv
module uart_tx_data
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        dataLen,
  input  logic [1:0]        parityMode,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txOut
);
  localparam int MAX_LEN_CODE = 3;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parBit;
  logic              parNext;
  logic              dataXor;

  assign lenMask = {DATA_W{1'b1}} >> (MAX_LEN_CODE - int'(dataLen));
  assign dataXor = ^(holdReg & lenMask);

  always_comb begin
    case (parMode_t'(parityMode))
      PAR_ODD:  parNext = ~dataXor;
      PAR_EVEN: parNext = dataXor;
      PAR_MARK: parNext = 1'b1;
      default:  parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (wrEn) holdReg <= wrData;
      if (wrEn)             holdFull <= 1'b1;
      else if (strobe.load) holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= holdReg;
      parBit   <= parNext;
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_START: txOut = 1'b0;
      LINE_DATA:  txOut = shiftReg[0];
      LINE_PAR:   txOut = parBit;
      default:    txOut = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W/2-1:0] divHi,
  input  logic [DIV_W/2-1:0] divLo,
  input  logic [1:0]        dataLen,
  input  logic              parityEn,
  input  logic [1:0]        parityMode,
  input  logic              twoStop,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqEnable,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              txEmpty,
  output logic              irq
);
  logic      tick;
  logic      holdFull;
  logic      busy;
  txStrobe_t strobe;

  uart_tx_tick #(.DIV_W(DIV_W)) uTick (
    .clk(clk), .rstN(rstN), .divisor({divHi, divLo}), .tick(tick)
  );

  uart_tx_ctrl #(.OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .holdFull(holdFull),
    .dataLen(dataLen), .parityEn(parityEn), .twoStop(twoStop),
    .strobe(strobe), .busy(busy)
  );

  uart_tx_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .dataLen(dataLen), .parityMode(parityMode), .strobe(strobe),
    .holdFull(holdFull), .txOut(txOut)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && !busy;
  assign irq       = holdEmpty && irqEnable;
endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        irqEnable,
  input logic [15:0] divAll,
  input logic        txOut,
  input logic        holdEmpty,
  input logic        txEmpty,
  input logic        irq
);
  // R1 / R8: a drained transmitter shows an idle line and an empty holding register
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txOut);
  a_r8_empty_needs_hold: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);
  // R7: a write clears the empty flag next cycle
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !holdEmpty);
  // R7: the flag only rises when a frame starts, so the transmitter is then busy
  a_r7_rise_at_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> (!txEmpty && !txOut));
  // R10: a masked interrupt never fires, and a write clears it
  a_r10_masked: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEnable);
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !irq);
  // R6: a zero divisor freezes the line
  a_r6_zero_div_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (divAll == 16'd0) |=> $stable(txOut));
endmodule

bind uart_tx_hold uart_tx_hold_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .irqEnable(irqEnable),
  .divAll({divHi, divLo}), .txOut(txOut), .holdEmpty(holdEmpty),
  .txEmpty(txEmpty), .irq(irq)
);

// File: tb/tb_uart_tx_hold.sv
module tb_uart_tx_hold;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divHi = 8'd0;
  logic [7:0] divLo = 8'd1;
  logic [1:0] dataLen = 2'd3;
  logic       parityEn = 1'b0;
  logic [1:0] parityMode = 2'd0;
  logic       twoStop = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       irqEnable = 1'b0;
  logic       txOut, holdEmpty, txEmpty, irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  uart_tx_hold dut (
    .clk(clk), .rstN(rstN), .divHi(divHi), .divLo(divLo),
    .dataLen(dataLen), .parityEn(parityEn), .parityMode(parityMode),
    .twoStop(twoStop), .wrEn(wrEn), .wrData(wrData), .irqEnable(irqEnable),
    .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int divVal();
    return int'({divHi, divLo});
  endfunction

  function automatic logic expPar(input logic [7:0] d);
    logic x;
    x = 1'b0;
    for (int i = 0; i < int'(dataLen) + 5; i++) x = x ^ d[i];
    case (parityMode)
      2'd0:    return ~x;
      2'd1:    return x;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitStart();
    while (txOut !== 1'b0) @(negedge clk);
  endtask

  // Called at the first negedge of the start bit; ends at mid of the last stop bit.
  task automatic captureFrame(input logic [7:0] d, input string tag);
    int dv;
    dv = divVal();
    waitN(8 * dv);
    check(txOut == 1'b0, {tag, " R2 start"}, int'(txOut), 0);
    for (int i = 0; i < int'(dataLen) + 5; i++) begin
      waitN(16 * dv);
      check(txOut == d[i], {tag, " R2 data bit"}, int'(txOut), int'(d[i]));
    end
    if (parityEn) begin
      waitN(16 * dv);
      check(txOut == expPar(d), {tag, " R3 parity"}, int'(txOut), int'(expPar(d)));
    end
    waitN(16 * dv);
    check(txOut == 1'b1, {tag, " R4 stop1"}, int'(txOut), 1);
    if (twoStop) begin
      waitN(16 * dv);
      check(txOut == 1'b1, {tag, " R4 stop2"}, int'(txOut), 1);
    end
    check(txEmpty == 1'b0, {tag, " R8 busy in stop"}, int'(txEmpty), 0);
  endtask

  task automatic sendOne(input logic [7:0] d, input string tag);
    writeByte(d);
    waitStart();
    captureFrame(d, tag);
    waitN(8 * divVal() + 1);
    check(txEmpty == 1'b1 && txOut == 1'b1, {tag, " R8 drained"}, int'(txEmpty), 1);
  endtask

  task automatic testReset();
    check(txOut == 1'b1, "R1 reset txOut", int'(txOut), 1);
    check(holdEmpty == 1'b1, "R1 reset holdEmpty", int'(holdEmpty), 1);
    check(txEmpty == 1'b1, "R1 reset txEmpty", int'(txEmpty), 1);
    check(irq == 1'b0, "R1 reset irq", int'(irq), 0);
  endtask

  task automatic testBasic();
    divHi = 0; divLo = 1; dataLen = 3; parityEn = 0; twoStop = 0;
    writeByte(8'hA5);
    check(holdEmpty == 1'b0, "R7 cleared after write", int'(holdEmpty), 0);
    @(negedge clk);
    check(holdEmpty == 1'b1, "R7 set at transfer", int'(holdEmpty), 1);
    check(txOut == 1'b0, "R7 start with transfer", int'(txOut), 0);
    check(txEmpty == 1'b0, "R8 busy after transfer", int'(txEmpty), 0);
    captureFrame(8'hA5, "basic");
    waitN(9);
    check(txEmpty == 1'b1, "R8 drained after stop", int'(txEmpty), 1);
    check(txOut == 1'b1, "R1 idle high", int'(txOut), 1);
  endtask

  task automatic testFormats();
    dataLen = 0; parityEn = 1; parityMode = 1; twoStop = 0;
    sendOne(8'hF6, "5E1 R3");
    dataLen = 2; parityMode = 0; twoStop = 1;
    sendOne(8'h5B, "7O2 R3 R4");
    dataLen = 1; parityMode = 2; twoStop = 0;
    sendOne(8'h2A, "6M1 R3");
    dataLen = 3; parityMode = 3; twoStop = 1;
    sendOne(8'hFF, "8S2 R3");
    parityEn = 0; twoStop = 0;
  endtask

  task automatic testBackToBack();
    writeByte(8'h3C);
    waitStart();
    begin
      writeByte(8'hC3);
      check(holdEmpty == 1'b0, "R9 second byte pending", int'(holdEmpty), 0);
      captureFrame(8'h3C, "b2b first");
    end
    waitN(8);
    check(txOut == 1'b0, "R9 next start without gap", int'(txOut), 0);
    captureFrame(8'hC3, "b2b second R9");
    waitN(9);
    check(txEmpty == 1'b1, "R9 drained", int'(txEmpty), 1);
  endtask

  task automatic testIrq();
    irqEnable = 1;
    @(negedge clk);
    check(irq == 1'b1, "R10 pending when idle", int'(irq), 1);
    writeByte(8'h81);
    check(irq == 1'b0, "R10 cleared by write", int'(irq), 0);
    waitStart();
    check(irq == 1'b1, "R10 raised at transfer", int'(irq), 1);
    irqEnable = 0;
    @(negedge clk);
    check(irq == 1'b0, "R10 masked", int'(irq), 0);
    while (txEmpty !== 1'b1) @(negedge clk);
  endtask

  task automatic measureStart(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    int lowCnt;
    divHi = hi; divLo = lo;
    writeByte(8'h01);
    waitStart();
    lowCnt = 0;
    while (txOut == 1'b0) begin
      lowCnt++;
      @(negedge clk);
    end
    check(lowCnt == 16 * divVal(), tag, lowCnt, 16 * divVal());
    while (txEmpty !== 1'b1) @(negedge clk);
  endtask

  task automatic testDivisor();
    measureStart(8'd0, 8'd3, "R5 bit length div 3");
    measureStart(8'd1, 8'd0, "R5 bit length high byte");
    divHi = 0; divLo = 1;
  endtask

  task automatic testZeroAndReplace();
    divHi = 0; divLo = 0;
    writeByte(8'h11);
    waitN(100);
    check(txOut == 1'b1, "R6 no progress on zero divisor", int'(txOut), 1);
    check(holdEmpty == 1'b0, "R6 byte kept pending", int'(holdEmpty), 0);
    writeByte(8'h3C);
    divLo = 1;
    waitStart();
    captureFrame(8'h3C, "R11 replaced byte");
    waitN(40);
    check(txEmpty == 1'b1 && txOut == 1'b1, "R11 only one frame", int'(txOut), 1);
  endtask

  initial begin
    waitN(150000);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitN(4);
    rstN = 1'b1;
    waitN(2);
    testReset();
    testBasic();
    testFormats();
    testBackToBack();
    testIrq();
    testDivisor();
    testZeroAndReplace();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule